// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two 32-bit entries from memory. The first entry comes from a directory. The directory's base is supplied by a control input. The second entry comes from the page table that the directory entry points to.

The address is split into three fields: bits 31:22 index the directory, bits 21:12 index the page table, and bits 11:0 are the byte offset within the page. Each entry fetch is word-aligned, at base plus index times four.

Each request carries two attributes: whether it is a write, and whether it comes from user or supervisor level. Each level of the walk is checked for presence, reserved bits, user access and write permission. A failed check ends the walk with a fault cause code and latches the faulting linear address.

When translation is switched off, the address comes back unchanged after one cycle. A successful walk also reports the addresses of the two entries it used, so that an outside agent can set their accessed flags.

Entry layout, low bits:

| Bit | Meaning |
|-----|---------|
| 0 | present |
| 1 | writable |
| 2 | user |
| 5 | accessed |
| 7 | page size |

Bits 11:8 are reserved. Bits 31:12 hold a 4 KB-aligned base.

Top module: `ptw_walker`

## Requirements
- R1: When the paging-enable input or the protection-enable input is 0, an accepted request returns rsp_valid in the cycle after acceptance, with rsp_paddr equal to the request address, rsp_fault 0, and no memory read.
- R2: The first read is at {dir_base[31:12], va[31:22], 2'b00}, so the low 12 bits of the directory base have no effect. The second read is at {directory entry[31:12], va[21:12], 2'b00}.
- R3: A walk without fault returns rsp_paddr = {table entry[31:12], va[11:0]}, with rsp_fault 0 and rsp_cause 0.
- R4: A directory entry with bit 0 clear ends the walk with rsp_cause 1. No page-table read is made.
- R5: A table entry with bit 0 clear ends the walk with rsp_cause 2.
- R6: A present entry is a reserved-bit fault (rsp_cause 5) if any of its bits 11:8 is set. A present directory entry with bit 7 set is also a reserved-bit fault. The presence check comes first.
- R7: A user request faults with rsp_cause 4 when either entry has bit 2 clear. This check takes precedence over the write check.
- R8: A write faults with rsp_cause 3 when either entry has bit 1 clear, in two cases: when the request is from user level, or when the request is from supervisor level and the write-protect input is 1. A supervisor write with write-protect 0 succeeds.
- R9: On every fault, fault_addr takes the faulting linear address in the cycle rsp_valid rises. It keeps that value through later successful walks and pass-through requests.
- R10: A successful walk pulses acc_set together with rsp_valid. acc_dir_addr and acc_tbl_addr give the two entry addresses read. acc_set stays low on faults and on pass-through.
- R11: After reset, ready is 1 and rsp_valid, mem_rd_en and fault_addr are 0. Each response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request, accepted when ready is 1 |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-level access |
| ready | output | 1 | Walker idle, can accept a request |
| ctl_pg_en | input | 1 | Paging enable |
| ctl_prot_en | input | 1 | Protection enable |
| ctl_wr_prot | input | 1 | Write-protect for supervisor writes |
| ctl_dir_base | input | 32 | Directory base physical address |
| mem_rd_en | output | 1 | Entry read request, held until mem_rd_valid |
| mem_rd_addr | output | 32 | Entry read address |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_data | input | 32 | Entry read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 3 | Fault cause (0 none, 1-5 per R4-R8) |
| fault_addr | output | 32 | Last faulting linear address |
| acc_set | output | 1 | Request to set accessed flags |
| acc_dir_addr | output | 32 | Directory entry address used |
| acc_tbl_addr | output | 32 | Table entry address used |

## Verification
The user check and the write check are evaluated on the same table entry in the same cycle. The bench provokes both at once with a user write to a page that is both supervisor-only and read-only, and expects the privilege cause alone. A second case makes a present bit and a reserved bit disagree in the same entry. Here the not-present cause is expected to win. Fault-address capture and the response strobe also share a cycle, so fault_addr is sampled on the very cycle rsp_valid is high.

// File: rtl/ptw_walker.sv
module ptw_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        ready,
  input  logic        ctl_pg_en,
  input  logic        ctl_prot_en,
  input  logic        ctl_wr_prot,
  input  logic [31:0] ctl_dir_base,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [2:0]  rsp_cause,
  output logic [31:0] fault_addr,
  output logic        acc_set,
  output logic [31:0] acc_dir_addr,
  output logic [31:0] acc_tbl_addr
);
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_PS = 7;

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_DIRNP = 3'd1;
  localparam logic [2:0] C_TBLNP = 3'd2;
  localparam logic [2:0] C_WRITE = 3'd3;
  localparam logic [2:0] C_PRIV  = 3'd4;
  localparam logic [2:0] C_RSVD  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_DONE} state_t;
  state_t state;

  logic [31:0] va_q, pde_q, paddr_q, faddr_q, dir_ea_q, tbl_ea_q;
  logic        wr_q, us_q, fault_q, acc_q;
  logic [2:0]  cause_q, cause;

  wire [31:0] dir_ea = {ctl_dir_base[31:12], va_q[31:22], 2'b00};
  wire [31:0] tbl_ea = {pde_q[31:12], va_q[21:12], 2'b00};
  wire [31:0] e      = mem_rd_data;
  wire        rsvd   = |e[11:8];
  wire        usr_ok = pde_q[BIT_U] & e[BIT_U];
  wire        wr_ok  = pde_q[BIT_W] & e[BIT_W];

  always_comb begin
    cause = C_NONE;
    if (state == S_DIR) begin
      if (!e[BIT_P])              cause = C_DIRNP;
      else if (rsvd || e[BIT_PS]) cause = C_RSVD;
    end else if (state == S_TBL) begin
      if (!e[BIT_P])                                  cause = C_TBLNP;
      else if (rsvd)                                  cause = C_RSVD;
      else if (us_q && !usr_ok)                       cause = C_PRIV;
      else if (wr_q && !wr_ok && (us_q || ctl_wr_prot)) cause = C_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      va_q     <= '0;
      pde_q    <= '0;
      paddr_q  <= '0;
      faddr_q  <= '0;
      dir_ea_q <= '0;
      tbl_ea_q <= '0;
      wr_q     <= 1'b0;
      us_q     <= 1'b0;
      fault_q  <= 1'b0;
      acc_q    <= 1'b0;
      cause_q  <= C_NONE;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          us_q    <= req_user;
          fault_q <= 1'b0;
          cause_q <= C_NONE;
          acc_q   <= 1'b0;
          if (ctl_pg_en && ctl_prot_en) begin
            state <= S_DIR;
          end else begin
            paddr_q <= req_vaddr;
            state   <= S_DONE;
          end
        end
        S_DIR: if (mem_rd_valid) begin
          if (cause != C_NONE) begin
            fault_q <= 1'b1;
            cause_q <= cause;
            faddr_q <= va_q;
            paddr_q <= '0;
            state   <= S_DONE;
          end else begin
            pde_q    <= e;
            dir_ea_q <= dir_ea;
            state    <= S_TBL;
          end
        end
        S_TBL: if (mem_rd_valid) begin
          if (cause != C_NONE) begin
            fault_q <= 1'b1;
            cause_q <= cause;
            faddr_q <= va_q;
            paddr_q <= '0;
          end else begin
            paddr_q  <= {e[31:12], va_q[11:0]};
            tbl_ea_q <= tbl_ea;
            acc_q    <= 1'b1;
          end
          state <= S_DONE;
        end
        default: begin
          acc_q <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign ready        = (state == S_IDLE);
  assign mem_rd_en    = (state == S_DIR) || (state == S_TBL);
  assign mem_rd_addr  = (state == S_TBL) ? tbl_ea : dir_ea;
  assign rsp_valid    = (state == S_DONE);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign rsp_cause    = cause_q;
  assign fault_addr   = faddr_q;
  assign acc_set      = (state == S_DONE) && acc_q;
  assign acc_dir_addr = dir_ea_q;
  assign acc_tbl_addr = tbl_ea_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_write,
  input logic        req_user,
  input logic        ready,
  input logic        ctl_pg_en,
  input logic        ctl_prot_en,
  input logic        ctl_wr_prot,
  input logic [31:0] ctl_dir_base,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_data,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [2:0]  rsp_cause,
  input logic [31:0] fault_addr,
  input logic        acc_set,
  input logic [31:0] acc_dir_addr,
  input logic [31:0] acc_tbl_addr
);
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid && !(ctl_pg_en && ctl_prot_en)) |=>
      (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr) && !mem_rd_en));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00 && !ready));

  // R3
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 3'd0));

  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause >= 3'd1 && rsp_cause <= 3'd5));

  // R9
  faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (rsp_valid && rsp_fault));

  // R10
  acc_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_set |-> (rsp_valid && !rsp_fault));

  // R11
  one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && ready));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        ready;
  logic        ctl_pg_en = 1'b1, ctl_prot_en = 1'b1, ctl_wr_prot = 1'b0;
  logic [31:0] ctl_dir_base = 32'h0000_1ABC;
  logic        mem_rd_en, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        rsp_valid, rsp_fault, acc_set;
  logic [31:0] rsp_paddr, fault_addr, acc_dir_addr, acc_tbl_addr;
  logic [2:0]  rsp_cause;

  int checks = 0, errors = 0;
  int nreads = 0;
  logic [31:0] rd_log [0:3];
  logic [31:0] mem [0:4095];

  int          lat;
  logic [31:0] r_pa, r_fa, r_da, r_ta;
  logic        r_f, r_acc;
  logic [2:0]  r_c;

  localparam logic [31:0] VA = 32'h0040_3123;
  localparam int DIRW = 1024 + 1;
  localparam int TBLW = 2048 + 3;

  always #10 clk = ~clk;

  ptw_walker uut (.*);

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en && !mem_rd_valid;
    mem_rd_data  <= mem[mem_rd_addr[13:2]];
    if (mem_rd_en && !mem_rd_valid) begin
      if (nreads < 4) rd_log[nreads] <= mem_rd_addr;
      nreads <= nreads + 1;
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic [19:0] base, input logic [11:0] fl);
    return {base, fl};
  endfunction

  task automatic setup(input logic [11:0] dfl, input logic [11:0] tfl);
    mem[DIRW] = ent(20'h00002, dfl);
    mem[TBLW] = ent(20'hABCDE, tfl);
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic us);
    @(negedge clk);
    nreads = 0;
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    r_pa = rsp_paddr; r_f = rsp_fault; r_c = rsp_cause; r_fa = fault_addr;
    r_acc = acc_set; r_da = acc_dir_addr; r_ta = acc_tbl_addr;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R11 reset handshake",
        {29'd0, ready, rsp_valid, mem_rd_en}, 32'h4);
    chk(fault_addr === 32'h0, "R11 reset fault_addr", fault_addr, 32'h0);
  endtask

  task automatic t_passthru();
    ctl_pg_en = 1'b0;
    walk(32'hDEAD_B123, 1'b0, 1'b0);
    chk(lat == 1 && r_pa == 32'hDEAD_B123 && !r_f, "R1 paging off", r_pa, 32'hDEAD_B123);
    chk(nreads == 0 && !r_acc, "R1 no read", nreads, 0);
    ctl_pg_en = 1'b1; ctl_prot_en = 1'b0;
    walk(32'h1234_5678, 1'b1, 1'b1);
    chk(lat == 1 && r_pa == 32'h1234_5678 && !r_f, "R1 protection off", r_pa, 32'h1234_5678);
    ctl_prot_en = 1'b1;
  endtask

  task automatic t_success();
    setup(12'h007, 12'h007);
    walk(VA, 1'b1, 1'b1);
    chk(nreads == 2 && rd_log[0] == 32'h1004, "R2 directory read addr", rd_log[0], 32'h1004);
    chk(rd_log[1] == 32'h200C, "R2 table read addr", rd_log[1], 32'h200C);
    chk(!r_f && r_c == 3'd0 && r_pa == 32'hABCD_E123, "R3 translated addr", r_pa, 32'hABCD_E123);
    chk(r_acc && r_da == 32'h1004 && r_ta == 32'h200C, "R10 accessed request", r_da, 32'h1004);
  endtask

  task automatic t_dir_np();
    setup(12'hF06, 12'h007);
    walk(VA, 1'b0, 1'b0);
    chk(r_f && r_c == 3'd1, "R4 directory not present", r_c, 1);
    chk(nreads == 1 && !r_acc, "R4 no table read", nreads, 1);
    chk(r_fa == VA, "R9 fault addr captured", r_fa, VA);
  endtask

  task automatic t_tbl_np();
    setup(12'h007, 12'h106);
    walk(32'h0040_3FFC, 1'b0, 1'b0);
    chk(r_f && r_c == 3'd2 && !r_acc, "R5 table not present over reserved", r_c, 2);
    chk(r_fa == 32'h0040_3FFC, "R9 fault addr", r_fa, 32'h0040_3FFC);
  endtask

  task automatic t_rsvd();
    setup(12'h087, 12'h007);
    walk(VA, 1'b0, 1'b0);
    chk(r_f && r_c == 3'd5 && nreads == 1, "R6 directory size bit", r_c, 5);
    setup(12'h007, 12'h807);
    walk(VA, 1'b0, 1'b0);
    chk(r_f && r_c == 3'd5, "R6 table reserved bit", r_c, 5);
    setup(12'h207, 12'h007);
    walk(VA, 1'b0, 1'b0);
    chk(r_f && r_c == 3'd5, "R6 directory reserved bit", r_c, 5);
  endtask

  task automatic t_priv();
    setup(12'h003, 12'h005);
    walk(VA, 1'b1, 1'b1);
    chk(r_f && r_c == 3'd4, "R7 user write to supervisor read-only", r_c, 4);
    setup(12'h007, 12'h003);
    walk(VA, 1'b0, 1'b1);
    chk(r_f && r_c == 3'd4, "R7 user read supervisor page", r_c, 4);
    walk(VA, 1'b0, 1'b0);
    chk(!r_f && r_pa == 32'hABCD_E123, "R7 supervisor read ok", r_pa, 32'hABCD_E123);
  endtask

  task automatic t_write();
    setup(12'h005, 12'h007);
    walk(VA, 1'b1, 1'b1);
    chk(r_f && r_c == 3'd3, "R8 user write read-only", r_c, 3);
    ctl_wr_prot = 1'b0;
    walk(VA, 1'b1, 1'b0);
    chk(!r_f && r_pa == 32'hABCD_E123, "R8 supervisor write wp off", r_pa, 32'hABCD_E123);
    ctl_wr_prot = 1'b1;
    walk(32'h0040_3000, 1'b1, 1'b0);
    chk(r_f && r_c == 3'd3, "R8 supervisor write wp on", r_c, 3);
    walk(VA, 1'b0, 1'b1);
    chk(!r_f, "R8 user read read-only ok", r_c, 0);
    ctl_wr_prot = 1'b0;
  endtask

  task automatic t_hold();
    setup(12'h006, 12'h007);
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    chk(r_fa == 32'h0040_3ABC, "R9 capture", r_fa, 32'h0040_3ABC);
    setup(12'h007, 12'h007);
    walk(VA, 1'b0, 1'b0);
    chk(!r_f && r_fa == 32'h0040_3ABC, "R9 held over success", r_fa, 32'h0040_3ABC);
    ctl_pg_en = 1'b0;
    walk(32'h0000_0010, 1'b0, 1'b0);
    chk(r_fa == 32'h0040_3ABC && !r_acc, "R9 R10 held over passthrough", r_fa, 32'h0040_3ABC);
    ctl_pg_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_passthru();
    t_success();
    t_dir_np();
    t_tbl_np();
    t_rsvd();
    t_priv();
    t_write();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule